// File: doc/BRIEF.md
# Serial Shift Output Controller

This block expands a 32-bit output word onto an external chain of serial-in, parallel-out shift registers using three wires: a serial data line, a shift clock and a store strobe. Software programs the word and a control register through a two-location register port. Each 8-bit group of the word can be included in or left out of the chain, so a board that fits fewer external registers shifts only the bits it has.

A transfer shifts the enabled bits of a snapshot of the word and then pulses the store strobe. Transfers start on an update event. The event comes from one of three sources: a self-clearing software bit, a divided tick from a general-purpose timer, or a divided tick from a fixed peripheral clock. The shift-clock rate and the shift-clock edge on which data changes are programmable. An event that arrives while a transfer is running is queued, and the queued event runs right after the current transfer ends.

Top module: `shift_out_ctrl`

## Requirements
- R1: After reset both registers read zero, the shift clock, data and store strobe are low, and busy is low.
- R2: Location 0 holds the word. Location 1 holds the control fields: bits [3:0] group enable, [5:4] update source, [7:6] shift-clock rate, [8] launch edge, [10:9] fixed-tick rate, [12:11] timer-tick rate. Bit 13 is read-only and reads 1 exactly when the source is 1 or 2. Bit 16 is the software-update bit and bit 17 reads busy.
- R3: A transfer shifts 8 bits for each enabled group. With no group enabled, an event produces no shift clock and no strobe, and the software-update bit clears by itself.
- R4: The enabled groups go out highest-numbered group first, each group most-significant bit first.
- R5: The shift clock idles low. Each of its high and low halves lasts 4 << rate system cycles.
- R6: With launch edge 0, data changes only on rising shift-clock edges. With launch edge 1, data changes only on falling edges, or at the start of the transfer before the first rising edge.
- R7: After the last falling shift-clock edge, the store strobe is high for two half periods with the shift clock low. Busy drops in the same cycle the strobe falls.
- R8: With source 0, writing location 1 with bit 16 set starts one transfer. Bit 16 and bit 17 read 1 until that transfer completes, then both read 0.
- R9: With source 1, a transfer starts on every (1 << timer rate)-th timer tick.
- R10: With source 2, a transfer starts on every (4 << fixed rate)-th fixed tick.
- R11: Events that arrive during a transfer merge into one queued transfer, which runs right after the current one.
- R12: A transfer uses the word, groups, rate and edge in force when it starts. Writes made during the transfer do not change it.
- R13: With source 1, 2 or 3, bit 16 of a write is ignored and reads 0. Source 3 starts no transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 word, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tmr_tick | input | 1 | One-cycle tick from the general-purpose timer |
| fix_tick | input | 1 | One-cycle tick derived from the fixed peripheral clock |
| sclk_o | output | 1 | Shift clock to the external chain |
| sdata_o | output | 1 | Serial data to the external chain |
| latch_o | output | 1 | Store strobe to the external chain |
| busy_o | output | 1 | High while a transfer runs |

## Verification
The bench checks sparse group masks such as 0101. A design that did not compact the enabled groups would shift bits from disabled groups or the wrong number of bits. It checks both launch edges at every rate. Data that changed on the sampling edge, or a half period off by a factor of two, shows up as a wrong captured word or a rejected width. Events issued while a transfer is running must give exactly one extra transfer, so a design that dropped them or ran each one separately gives the wrong transfer count. The bench also writes the registers in the middle of a transfer, issues an event with no group enabled, and sends ticks one short of the divide ratio; a design without snapshots, without the empty-mask shortcut or with an off-by-one divider fails these checks.

// File: rtl/shift_out_pkg.sv
`timescale 1ns/1ps
// Package: shared control layout and source encoding for the serial
// shift output controller. Assumes a 4-group word.
package shift_out_pkg;
    localparam int NGRP     = 4;
    localparam int CTRL_W   = 13;
    localparam int SWU_BIT  = 16;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_NONE  = 2'd3
    } upd_src_e;

    // Field order, LSB first: groups, source, rate, edge, fixed rate, timer rate.
    typedef struct packed {
        logic [1:0]  tmr_rate;
        logic [1:0]  fix_rate;
        logic        edge_sel;
        logic [1:0]  sck_rate;
        upd_src_e    src;
        logic [NGRP-1:0] grp_en;
    } ctrl_t;
endpackage

// File: rtl/shift_out_regs.sv
`timescale 1ns/1ps
// Register file: word and control registers, the self-clearing software
// update bit and the read mux. Assumes W >= 18 so the status bits fit.
module shift_out_regs
    import shift_out_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    input  logic         busy,
    input  logic         done,
    input  logic         queued,
    output logic [W-1:0] word,
    output ctrl_t        ctrl,
    output logic         swu,
    output logic         sw_evt,
    output logic [W-1:0] rdata
);
    ctrl_t wctrl;
    logic  refresh;
    logic  unused_wbits;

    assign wctrl        = ctrl_t'(wdata[CTRL_W-1:0]);
    assign unused_wbits = ^{wdata[W-1:SWU_BIT+1], wdata[SWU_BIT-1:CTRL_W]};
    assign sw_evt       = wr && sel && wdata[SWU_BIT] && (wctrl.src == SRC_SOFT);
    assign refresh      = (ctrl.src == SRC_TIMER) || (ctrl.src == SRC_FIXED);

    // Purpose: hold the word and control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            ctrl <= '0;
        end else if (wr) begin
            if (sel) ctrl <= wctrl;
            else     word <= wdata;
        end
    end

    // Purpose: software-update bit, set by a trigger write, cleared when nothing is left to run.
    always_ff @(posedge clk) begin
        if (!rst_n)                swu <= 1'b0;
        else if (sw_evt)           swu <= 1'b1;
        else if (done && !queued)  swu <= 1'b0;
    end

    // Purpose: read mux, status bits assembled beside the control fields.
    always_comb begin
        if (!sel) rdata = word;
        else      rdata = W'({busy, swu, 2'b00, refresh, ctrl});
    end

    assert_swu_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> swu);
endmodule

// File: rtl/shift_out_tickdiv.sv
`timescale 1ns/1ps
// Tick divider: passes every (BASE << sel)-th input tick while active.
// The count restarts whenever the divider is inactive.
module shift_out_tickdiv #(
    parameter int BASE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       pulse
);
    localparam int MAXDIV = BASE * 8;
    localparam int CW     = $clog2(MAXDIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last  = CW'(BASE << sel) - CW'(1);
    assign pulse = active && tick && (cnt >= last);

    // Purpose: count input ticks up to the selected ratio.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else if (tick)    cnt <= pulse ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/shift_out_seq.sv
`timescale 1ns/1ps
// Shift/store sequencer: snapshots the enabled groups of the word,
// shifts them out MSB first with a divided shift clock, then pulses the
// store strobe. Events arriving while busy are merged into one queued run.
module shift_out_seq #(
    parameter int W         = 32,
    parameter int NG        = 4,
    parameter int HALF_BASE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [W-1:0]  word,
    input  logic [NG-1:0] grp_en,
    input  logic [1:0]    rate,
    input  logic          edge_sel,
    output logic          sclk,
    output logic          sdata,
    output logic          latch,
    output logic          busy,
    output logic          done,
    output logic          queued
);
    localparam int GW  = W / NG;
    localparam int BCW = $clog2(W + 1);
    localparam int HCW = $clog2(HALF_BASE * 16 + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH} st_e;

    st_e            st;
    logic           pend;
    logic           edge_q;
    logic [W-1:0]   shreg;
    logic [W-1:0]   packed_w;
    logic [W-1:0]   aligned;
    logic [BCW-1:0] nbits;
    logic [BCW-1:0] left;
    logic [HCW-1:0] half;
    logic [HCW-1:0] half_q;
    logic [HCW-1:0] hcnt;

    assign busy   = (st != ST_IDLE);
    assign queued = pend || start_req;
    assign half   = HCW'(HALF_BASE) << rate;

    // Purpose: pack enabled groups (highest first) and left-justify them.
    always_comb begin
        packed_w = '0;
        nbits    = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (grp_en[g]) begin
                packed_w = (packed_w << GW) | W'(word[g*GW +: GW]);
                nbits    = nbits + BCW'(GW);
            end
        end
        aligned = packed_w << (BCW'(W) - nbits);
    end

    // Purpose: transfer state machine, shift clock, data launch and store strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pend   <= 1'b0;
            edge_q <= 1'b0;
            shreg  <= '0;
            left   <= '0;
            half_q <= '0;
            hcnt   <= '0;
            sclk   <= 1'b0;
            sdata  <= 1'b0;
            latch  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_req || pend) begin
                        pend <= 1'b0;
                        if (nbits == '0) begin
                            done <= 1'b1;
                        end else begin
                            st     <= ST_SHIFT;
                            shreg  <= aligned;
                            left   <= nbits;
                            half_q <= half;
                            hcnt   <= half - HCW'(1);
                            edge_q <= edge_sel;
                            if (edge_sel) sdata <= aligned[W-1];
                        end
                    end
                end
                ST_SHIFT: begin
                    if (start_req) pend <= 1'b1;
                    if (hcnt != '0) begin
                        hcnt <= hcnt - HCW'(1);
                    end else if (!sclk) begin
                        hcnt <= half_q - HCW'(1);
                        sclk <= 1'b1;
                        if (!edge_q) sdata <= shreg[W-1];
                    end else begin
                        sclk  <= 1'b0;
                        shreg <= shreg << 1;
                        left  <= left - BCW'(1);
                        if (left == BCW'(1)) begin
                            st    <= ST_LATCH;
                            latch <= 1'b1;
                            hcnt  <= (half_q << 1) - HCW'(1);
                        end else begin
                            hcnt <= half_q - HCW'(1);
                            if (edge_q) sdata <= shreg[W-2];
                        end
                    end
                end
                ST_LATCH: begin
                    if (start_req) pend <= 1'b1;
                    if (hcnt != '0) begin
                        hcnt <= hcnt - HCW'(1);
                    end else begin
                        latch <= 1'b0;
                        st    <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_latch_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !sclk);
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !latch));
    assert_end_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(latch));
    assert_latch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) |=> latch);
endmodule

// File: rtl/shift_out_ctrl.sv
`timescale 1ns/1ps
// Top: serial shift output controller. Joins the register file, the two
// tick dividers, the update-source mux and the shift/store sequencer.
// Assumes ticks are one-cycle pulses in the clk domain.
module shift_out_ctrl
    import shift_out_pkg::*;
#(
    parameter int W         = 32,
    parameter int HALF_BASE = 4,
    parameter int TMR_BASE  = 1,
    parameter int FIX_BASE  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         tmr_tick,
    input  logic         fix_tick,
    output logic         sclk_o,
    output logic         sdata_o,
    output logic         latch_o,
    output logic         busy_o
);
    logic [W-1:0] word;
    ctrl_t        ctrl;
    logic         swu, sw_evt, done, queued;
    logic         tmr_pulse, fix_pulse, evt_q;

    shift_out_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .busy(busy_o), .done(done), .queued(queued),
        .word(word), .ctrl(ctrl), .swu(swu), .sw_evt(sw_evt), .rdata(reg_rdata)
    );

    shift_out_tickdiv #(.BASE(TMR_BASE)) u_tmr_div (
        .clk(clk), .rst_n(rst_n), .active(ctrl.src == SRC_TIMER),
        .tick(tmr_tick), .sel(ctrl.tmr_rate), .pulse(tmr_pulse)
    );

    shift_out_tickdiv #(.BASE(FIX_BASE)) u_fix_div (
        .clk(clk), .rst_n(rst_n), .active(ctrl.src == SRC_FIXED),
        .tick(fix_tick), .sel(ctrl.fix_rate), .pulse(fix_pulse)
    );

    // Purpose: register the merged update event so the sequencer sees settled control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= sw_evt || tmr_pulse || fix_pulse;
    end

    shift_out_seq #(.W(W), .NG(NGRP), .HALF_BASE(HALF_BASE)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(evt_q), .word(word),
        .grp_en(ctrl.grp_en), .rate(ctrl.sck_rate), .edge_sel(ctrl.edge_sel),
        .sclk(sclk_o), .sdata(sdata_o), .latch(latch_o), .busy(busy_o),
        .done(done), .queued(queued)
    );
endmodule

// File: tb/shift_out_ctrl_test.sv
`timescale 1ns/1ps
module shift_out_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tmr_tick = 1'b0;
    logic        fix_tick = 1'b0;
    logic        sclk_o, sdata_o, latch_o, busy_o;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    shift_out_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_tick(tmr_tick),
        .fix_tick(fix_tick), .sclk_o(sclk_o), .sdata_o(sdata_o),
        .latch_o(latch_o), .busy_o(busy_o)
    );

    always #2.5 clk = ~clk;

    // monitor state (written only by the monitor)
    int          exp_half = 4;
    bit          cur_edge = 1'b0;
    logic        p_sclk = 0, p_sdata = 0, p_busy = 0, p_latch = 0;
    int          hi_cnt = 0, lat_cnt = 0, ncap = 0;
    logic [31:0] cap = '0;
    int          xfers = 0;
    logic [31:0] last_cap = '0;
    int          last_n = 0, last_lw = 0;
    int          bad_half = 0, bad_launch = 0, bad_latch = 0, bad_busy = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_busy && sdata_o != p_sdata) begin
                if (cur_edge ? !(!sclk_o && p_sclk) : !(sclk_o && !p_sclk)) bad_launch++;
            end
            if (sclk_o && !p_sclk && cur_edge) begin cap = {cap[30:0], sdata_o}; ncap++; end
            if (!sclk_o && p_sclk) begin
                if (!cur_edge) begin cap = {cap[30:0], sdata_o}; ncap++; end
                if (hi_cnt != exp_half) bad_half++;
                hi_cnt = 0;
            end
            if (sclk_o) hi_cnt++;
            if (latch_o) begin lat_cnt++; if (sclk_o) bad_latch++; end
            if (!latch_o && p_latch) begin
                if (busy_o) bad_busy++;
                last_cap = cap; last_n = ncap; last_lw = lat_cnt;
                cap = '0; ncap = 0; lat_cnt = 0; xfers++;
            end
            p_sclk = sclk_o; p_sdata = sdata_o; p_busy = busy_o; p_latch = latch_o;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input bit sel, output logic [31:0] d);
        @(negedge clk); reg_sel = sel; #1; d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(input logic [3:0] g, input logic [1:0] s, input logic [1:0] r,
                                       input bit e, input logic [1:0] fr, input logic [1:0] tr);
        return {19'd0, tr, fr, e, r, s, g};
    endfunction

    function automatic logic [31:0] pack_exp(input logic [31:0] w, input logic [3:0] g, output int n);
        logic [31:0] v = '0;
        n = 0;
        for (int k = 3; k >= 0; k--) if (g[k]) begin v = (v << 8) | 32'(w[k*8 +: 8]); n += 8; end
        return v;
    endfunction

    task automatic wait_xfers(input int target);
        int t = 0;
        while (xfers < target && t < 6000) begin @(negedge clk); t++; end
    endtask

    task automatic pulse_tmr(); @(negedge clk); tmr_tick = 1; @(negedge clk); tmr_tick = 0; endtask
    task automatic pulse_fix(); @(negedge clk); fix_tick = 1; @(negedge clk); fix_tick = 0; endtask

    // one software-triggered transfer, checked against the bench model
    task automatic run_sw(input string req, input logic [31:0] w, input logic [3:0] g,
                          input logic [1:0] r, input bit e);
        int n; logic [31:0] ex; int base;
        ex = pack_exp(w, g, n);
        exp_half = 4 << r; cur_edge = e;
        base = xfers;
        wr(0, w);
        wr(1, mk(g, 2'd0, r, e, 2'd0, 2'd0) | 32'h0001_0000);
        wait_xfers(base + 1);
        @(negedge clk);
        check(xfers == base + 1, {req, " transfer count"}, xfers, base + 1);
        check(last_n == n && last_cap == ex, {req, " bits R4"}, last_cap, ex);
        check(last_lw == 2 * exp_half, {req, " strobe width R7"}, last_lw, 2 * exp_half);
        check(bad_half == 0 && bad_launch == 0 && bad_latch == 0 && bad_busy == 0,
              {req, " clock/launch R5 R6"}, bad_half + bad_launch + bad_latch + bad_busy, 0);
    endtask

    initial begin
        logic [31:0] d;
        int base;
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, d); check(d == 0, "R1 word", d, 0);
        rd(1, d); check(d == 0, "R1 control", d, 0);
        check({sclk_o, sdata_o, latch_o, busy_o} == 0, "R1 outputs", {sclk_o, sdata_o, latch_o, busy_o}, 0);

        // R2 readback and refresh bit
        wr(0, 32'h1234_ABCD); rd(0, d); check(d == 32'h1234_ABCD, "R2 word", d, 32'h1234_ABCD);
        wr(1, mk(4'hA, 2'd3, 2'd2, 1, 2'd1, 2'd3)); rd(1, d);
        check(d == mk(4'hA, 2'd3, 2'd2, 1, 2'd1, 2'd3), "R2 fields src3", d, mk(4'hA, 2'd3, 2'd2, 1, 2'd1, 2'd3));
        wr(1, mk(4'h1, 2'd1, 0, 0, 0, 0)); rd(1, d); check(d[13] == 1, "R2 refresh timer", d, 32'h2000);
        wr(1, mk(4'h1, 2'd2, 0, 0, 0, 0)); rd(1, d); check(d[13] == 1, "R2 refresh fixed", d, 32'h2000);
        wr(1, mk(4'h1, 2'd0, 0, 0, 0, 0)); rd(1, d); check(d[13] == 0, "R2 refresh soft", d, 0);

        // directed transfers (R3 R4 R5 R6 R7)
        run_sw("R4 full", 32'hA5C3_1E7F, 4'hF, 2'd0, 0);
        run_sw("R3 sparse", 32'h9F3C_5AE1, 4'b0101, 2'd1, 1);
        run_sw("R6 slow", 32'h8000_0001, 4'b1001, 2'd3, 0);
        run_sw("R6 single", 32'h0000_00C3, 4'b0001, 2'd2, 1);

        // constrained random transfers
        for (int i = 0; i < 16; i++) begin
            logic [3:0] g;
            g = 4'($urandom_range(1, 15));
            run_sw("R5 random", $urandom, g, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        end

        // R3 empty mask: no activity, software bit clears
        base = xfers;
        wr(1, mk(4'h0, 2'd0, 0, 0, 0, 0) | 32'h0001_0000);
        repeat (20) @(negedge clk);
        rd(1, d); check(d[16] == 0, "R3 empty swu clears", d, 0);
        check(xfers == base, "R3 empty no strobe", xfers, base);

        // R8 software bit and busy during a transfer
        exp_half = 4; cur_edge = 0; base = xfers;
        wr(0, 32'h0F0F_0F0F);
        wr(1, mk(4'hF, 2'd0, 0, 0, 0, 0) | 32'h0001_0000);
        rd(1, d); check(d[17:16] == 2'b11, "R8 swu and busy set", d[17:16], 3);
        wait_xfers(base + 1); repeat (3) @(negedge clk);
        rd(1, d); check(d[17:16] == 2'b00, "R8 swu and busy clear", d[17:16], 0);

        // R12 snapshot: writes during a transfer do not alter it
        base = xfers;
        wr(0, 32'hDEAD_BEEF);
        wr(1, mk(4'hF, 2'd0, 0, 0, 0, 0) | 32'h0001_0000);
        repeat (10) @(negedge clk);
        wr(0, 32'h1111_2222);
        wr(1, mk(4'h1, 2'd0, 0, 0, 0, 0));
        wait_xfers(base + 1); @(negedge clk);
        check(last_cap == 32'hDEAD_BEEF && last_n == 32, "R12 snapshot", last_cap, 32'hDEAD_BEEF);

        // R11 queued events merge into one
        wr(0, 32'h3C3C_A5A5);
        base = xfers;
        wr(1, mk(4'hF, 2'd0, 0, 0, 0, 0) | 32'h0001_0000);
        repeat (20) @(negedge clk);
        wr(1, mk(4'hF, 2'd0, 0, 0, 0, 0) | 32'h0001_0000);
        wr(1, mk(4'hF, 2'd0, 0, 0, 0, 0) | 32'h0001_0000);
        wait_xfers(base + 2); repeat (600) @(negedge clk);
        check(xfers == base + 2, "R11 merged count", xfers, base + 2);
        check(last_cap == 32'h3C3C_A5A5, "R11 queued data", last_cap, 32'h3C3C_A5A5);

        // R9 timer ticks divided by 2
        wr(0, 32'h0000_005A);
        wr(1, mk(4'h1, 2'd1, 0, 0, 0, 2'd1));
        base = xfers;
        pulse_tmr(); repeat (30) @(negedge clk);
        check(xfers == base, "R9 one tick short", xfers, base);
        pulse_tmr(); wait_xfers(base + 1); @(negedge clk);
        check(xfers == base + 1 && last_cap == 32'h5A, "R9 timer transfer", last_cap, 32'h5A);

        // R10 fixed ticks divided by 4
        wr(1, mk(4'h1, 2'd2, 0, 0, 2'd0, 0));
        base = xfers;
        repeat (3) pulse_fix(); repeat (30) @(negedge clk);
        check(xfers == base, "R10 three ticks", xfers, base);
        pulse_fix(); wait_xfers(base + 1); @(negedge clk);
        check(xfers == base + 1, "R10 fourth tick", xfers, base + 1);

        // R13 software bit ignored outside software mode; source 3 idle
        base = xfers;
        wr(1, mk(4'hF, 2'd3, 0, 0, 0, 0) | 32'h0001_0000);
        pulse_tmr(); pulse_fix(); repeat (40) @(negedge clk);
        rd(1, d); check(d[16] == 0, "R13 swu ignored src3", d, 0);
        check(xfers == base && busy_o == 0, "R13 no transfer src3", xfers, base);
        wr(1, mk(4'hF, 2'd1, 0, 0, 0, 2'd3) | 32'h0001_0000);
        repeat (40) @(negedge clk);
        rd(1, d); check(d[16] == 0, "R13 swu ignored timer", d, 0);
        check(xfers == base, "R13 no transfer timer", xfers, base);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule